// File: doc/BRIEF.md
# Programmable-Probability Random Event Generator

This block turns a pseudo-random bit stream into a sequence of yes/no events, each with a probability that a small table sets. A 16-bit shift register with a programmable feedback tap mask and a programmable reload seed steps once per enabled cycle. Its low byte is the random byte. Each cycle the random byte is compared with one of eight programmable 8-bit thresholds, chosen by a 3-bit index input. An event fires when the byte is below the threshold, so an entry of value v gives a probability of v/256 over a full register period.

A plain write port (address, data, strobe) loads the tap mask, the seed and the table. The random byte is a sliding window of the register, so decisions close together in time are correlated. A thinning input limits decisions to one in every sixteen shifts, which removes that correlation at the cost of rate. A stepping input freezes the generator. An all-zero register state reloads from the seed instead of locking up.

Top module: `bern_event_gen`

## Requirements
- R1: After reset the state is 0x0001, the tap mask is 0x0030, every table entry is 0, the shift counter is 0 and `fire_o` is low.
- R2: On a clock edge with `step_en` high and no seed load, the state moves one place toward the MSB. The new bit 0 is the XOR of the state bits selected by the tap mask. `rnd_o` always shows state bits [7:0].
- R3: With the reset tap mask 0x0030, after at least 16 shifts the state repeats every 63 shifts. With tap mask 0xD008, any nonzero state returns after exactly 65535 shifts and not sooner.
- R4: `fire_o` is high in the cycle after an edge where `step_en` was high, the decision slot was open and `rnd_o` was below the entry selected by `idx`. Otherwise `fire_o` is low. An entry of 0 never fires.
- R5: With `step_en` low, the state and the shift counter hold, and `fire_o` is low after that edge.
- R6: A shift from the all-zero state loads the stored seed instead of shifting.
- R7: A write to address 0 sets the tap mask, which is used from the next shift onward. A write to address 1 with nonzero data sets the seed and loads the state at the same edge, and this overrides the shift. Addresses 8 to 15 write table entry (address - 8) from `wr_data[7:0]`. Addresses 2 to 7 change nothing.
- R8: A write of zero to address 1 is ignored: the seed keeps its value and the state behaves as if no write occurred.
- R9: A 4-bit counter starts at 0 and increments on each shift, wrapping at 16. With `thin_en` high, a decision slot is open only on shifts where the counter reads 0. With `thin_en` low, every shift is a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the generator and make a decision this cycle |
| thin_en | input | 1 | Decide only once every sixteen shifts |
| idx | input | 3 | Table entry used for this cycle's comparison |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address (0 taps, 1 seed, 8-15 table) |
| wr_data | input | 16 | Write data; table writes use the low byte |
| fire_o | output | 1 | One-cycle event pulse |
| rnd_o | output | 8 | Current random byte (state bits [7:0]) |

## Verification
The assertions assume that `idx` and the write port are stable around the rising edge. They also assume that a seed load and a shift at the same edge resolve in favour of the load, so their shift checks are qualified by the absence of a nonzero seed write. The stimulus changes every input only on the falling edge. It writes at most one register per cycle, and it drives the all-zero state only through a zero tap mask, where the lock-up reload must appear. The stimulus deliberately tries zero seed writes and writes to unmapped addresses, and the bench model predicts that both leave the sequence undisturbed.

// File: rtl/bg_pkg.sv
package bg_pkg;
   // Write-port register selectors below the table window.
   localparam int unsigned REG_TAPS = 0;
   localparam int unsigned REG_SEED = 1;

   typedef struct packed {
      logic taps_we;
      logic seed_we;
      logic tab_we;
   } bg_wr_dec_t;
endpackage

// File: rtl/bg_lfsr.sv
module bg_lfsr #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] SEED_RST = 1,
   parameter logic [W-1:0] TAPS_RST = 'h30
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         taps_we,
   input  logic         seed_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] state_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("bg_lfsr: W must be at least 2");
      end
      if (SEED_RST == '0) begin : g_bad_seed
         $error("bg_lfsr: reset seed must be nonzero");
      end
   endgenerate

   logic [W-1:0] st_q, taps_q, seed_q;
   logic         load_ok;
   logic         fb;

   assign load_ok = seed_we && (wdata != '0);
   assign fb      = ^(st_q & taps_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEED_RST;
         taps_q <= TAPS_RST;
         seed_q <= SEED_RST;
      end else begin
         if (taps_we) taps_q <= wdata;
         if (load_ok) begin
            seed_q <= wdata;
            st_q   <= wdata;
         end else if (step) begin
            if (st_q == '0) st_q <= seed_q;
            else            st_q <= {st_q[W-2:0], fb};
         end
      end
   end

   assign state_o = st_q;

   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_ok && st_q != '0) |=> (st_q[W-1:1] == $past(st_q[W-2:0])));
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load_ok) |=> $stable(st_q));
   p_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_ok && st_q == '0) |=> (st_q == $past(seed_q)));
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_ok |=> (st_q == $past(wdata)));
   p_zero_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_we && wdata == '0) |=> $stable(seed_q));
endmodule

// File: rtl/bg_ptab.sv
module bg_ptab #(
   parameter int unsigned N  = 8,
   parameter int unsigned BW = 8,
   localparam int unsigned SW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] wsel,
   input  logic [BW-1:0] wbyte,
   input  logic [SW-1:0] rsel,
   output logic [BW-1:0] thr_o
);
   generate
      if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_depth
         $error("bg_ptab: N must be a power of two, at least 2");
      end
   endgenerate

   logic [BW-1:0] ent [N];

   for (genvar k = 0; k < N; k++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           ent[k] <= '0;
         else if (we && wsel == SW'(k))        ent[k] <= wbyte;
      end
   end

   assign thr_o = ent[rsel];
endmodule

// File: rtl/bg_decide.sv
module bg_decide #(
   parameter int unsigned BW   = 8,
   parameter int unsigned THIN = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          thin_en,
   input  logic [BW-1:0] byte_i,
   input  logic [BW-1:0] thr_i,
   output logic          fire_o
);
   logic slot;
   logic fire_q;

   generate
      if (THIN == 0 || (THIN & (THIN - 1)) != 0) begin : g_bad_thin
         $error("bg_decide: THIN must be a power of two");
      end
      if (THIN > 1) begin : g_thin
         localparam int unsigned CW = $clog2(THIN);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (step) cnt_q <= cnt_q + 1'b1;
         end
         assign slot = !thin_en || (cnt_q == '0);

         p_thin_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (thin_en && cnt_q != '0) |=> !fire_o);
         p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !step |=> $stable(cnt_q));
      end else begin : g_nothin
         assign slot = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fire_q <= 1'b0;
      else        fire_q <= step && slot && (byte_i < thr_i);
   end

   assign fire_o = fire_q;

   p_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> ($past(step) && ($past(byte_i) < $past(thr_i))));
   p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> !fire_o);
endmodule

// File: rtl/bern_event_gen.sv
module bern_event_gen #(
   parameter int unsigned LFSR_W      = 16,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned ENTRIES     = 8,
   parameter int unsigned THIN_PERIOD = 16,
   parameter logic [LFSR_W-1:0] TAPS_RST = 16'h0030,
   parameter logic [LFSR_W-1:0] SEED_RST = 16'h0001,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned ADDR_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              thin_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LFSR_W-1:0] wr_data,
   output logic              fire_o,
   output logic [BYTE_W-1:0] rnd_o
);
   import bg_pkg::*;

   generate
      if (LFSR_W < BYTE_W) begin : g_bad_w
         $error("bern_event_gen: LFSR_W must cover BYTE_W");
      end
      if (ENTRIES < 4) begin : g_bad_n
         $error("bern_event_gen: ENTRIES must leave room for taps and seed");
      end
   endgenerate

   bg_wr_dec_t dec;
   logic [LFSR_W-1:0] state;
   logic [BYTE_W-1:0] thr;

   always_comb begin
      dec         = '0;
      dec.taps_we = wr_en && (wr_addr == ADDR_W'(REG_TAPS));
      dec.seed_we = wr_en && (wr_addr == ADDR_W'(REG_SEED));
      dec.tab_we  = wr_en && wr_addr[ADDR_W-1];
   end

   bg_lfsr #(.W(LFSR_W), .SEED_RST(SEED_RST), .TAPS_RST(TAPS_RST)) i_lfsr (
      .clk(clk), .rst_n(rst_n), .step(step_en),
      .taps_we(dec.taps_we), .seed_we(dec.seed_we), .wdata(wr_data),
      .state_o(state)
   );

   bg_ptab #(.N(ENTRIES), .BW(BYTE_W)) i_tab (
      .clk(clk), .rst_n(rst_n), .we(dec.tab_we),
      .wsel(wr_addr[IDX_W-1:0]), .wbyte(wr_data[BYTE_W-1:0]),
      .rsel(idx), .thr_o(thr)
   );

   assign rnd_o = state[BYTE_W-1:0];

   bg_decide #(.BW(BYTE_W), .THIN(THIN_PERIOD)) i_dec (
      .clk(clk), .rst_n(rst_n), .step(step_en), .thin_en(thin_en),
      .byte_i(rnd_o), .thr_i(thr), .fire_o(fire_o)
   );

   p_onehot_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec.taps_we, dec.seed_we, dec.tab_we}));
endmodule

// File: tb/test_bern_event_gen.sv
module test_bern_event_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0, thin_en = 1'b0;
   logic [2:0]  idx = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        fire_o;
   logic [7:0]  rnd_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   bern_event_gen i_bern_event_gen (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .thin_en(thin_en), .idx(idx),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fire_o(fire_o), .rnd_o(rnd_o)
   );

   // Behavioural reference state
   logic [15:0] m_st, m_taps, m_seed;
   logic [7:0]  m_tab [8];
   int          m_cnt;
   logic        m_fire;
   int          n_vec = 0, n_bad = 0;
   bit          done = 0;
   string       cur_req = "R1";
   int          fires;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic parity_of_taps(input logic [15:0] s, input logic [15:0] t);
      logic p = 1'b0;
      for (int b = 0; b < 16; b++) if (t[b] && s[b]) p = ~p;
      return p;
   endfunction

   task automatic tick();
      logic [15:0] nst;
      logic        nf;
      nf  = step_en && (!thin_en || m_cnt == 0) && (m_st[7:0] < m_tab[idx]);
      nst = m_st;
      if (wr_en && wr_addr == 4'd1 && wr_data != 16'h0) nst = wr_data;
      else if (step_en) nst = (m_st == 16'h0) ? m_seed : {m_st[14:0], parity_of_taps(m_st, m_taps)};
      @(posedge clk);
      if (wr_en && wr_addr == 4'd0) m_taps = wr_data;
      if (wr_en && wr_addr == 4'd1 && wr_data != 16'h0) m_seed = wr_data;
      if (wr_en && wr_addr >= 4'd8) m_tab[wr_addr - 4'd8] = wr_data[7:0];
      if (step_en) m_cnt = (m_cnt + 1) % 16;
      m_st   = nst;
      m_fire = nf;
      @(negedge clk);
      check(rnd_o == m_st[7:0] && fire_o == m_fire, cur_req,
            {rnd_o, 7'd0, fire_o}, {m_st[7:0], 7'd0, m_fire});
      if (fire_o) fires++;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] win [63];
      bit         early;
      m_st = 16'h0001; m_taps = 16'h0030; m_seed = 16'h0001; m_cnt = 0; m_fire = 1'b0;
      for (int k = 0; k < 8; k++) m_tab[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(rnd_o == 8'h01, "R1", rnd_o, 8'h01);
      check(fire_o == 1'b0, "R1", fire_o, 0);

      // R7 table load, then R2/R4 running with varying index
      cur_req = "R7";
      wr(4'd8, 16'h0000); wr(4'd9, 16'h0020); wr(4'd10, 16'h0040); wr(4'd11, 16'h0060);
      wr(4'd12, 16'h0080); wr(4'd13, 16'h00A0); wr(4'd14, 16'h00C8); wr(4'd15, 16'h00FF);
      cur_req = "R2"; step_en = 1'b1;
      for (int c = 0; c < 150; c++) begin idx = 3'(c % 8); tick(); end

      // R3 default period 63
      cur_req = "R3";
      for (int c = 0; c < 63; c++) begin win[c] = rnd_o; tick(); end
      for (int c = 0; c < 63; c++) begin
         check(rnd_o == win[c], "R3", rnd_o, win[c]);
         tick();
      end

      // R4 entry 0 never fires
      cur_req = "R4"; idx = 3'd0; fires = 0;
      for (int c = 0; c < 64; c++) tick();
      check(fires == 0, "R4", fires, 0);
      idx = 3'd7; fires = 0;
      for (int c = 0; c < 64; c++) tick();
      check(fires > 50, "R4", fires, 63);

      // R5 stall
      cur_req = "R5"; step_en = 1'b0;
      begin
         logic [7:0] held;
         held = rnd_o;
         for (int c = 0; c < 5; c++) begin
            tick();
            check(rnd_o == held && !fire_o, "R5", rnd_o, held);
         end
      end
      step_en = 1'b1;

      // R9 thinning
      cur_req = "R9"; thin_en = 1'b1; idx = 3'd7; fires = 0;
      for (int c = 0; c < 160; c++) tick();
      check(fires <= 10 && fires > 0, "R9", fires, 10);
      thin_en = 1'b0;

      // R7 unmapped addresses have no effect
      cur_req = "R7";
      for (int a = 2; a < 8; a++) wr(4'(a), 16'hFFFF);
      tick();
      check(rnd_o == m_st[7:0], "R7", rnd_o, m_st[7:0]);

      // R8 zero seed write ignored
      cur_req = "R8";
      wr(4'd1, 16'h0000);
      check(rnd_o == m_st[7:0] && m_seed == 16'h0001, "R8", rnd_o, m_st[7:0]);

      // R7 nonzero seed loads immediately
      cur_req = "R7";
      wr(4'd1, 16'hACE1);
      check(rnd_o == 8'hE1, "R7", rnd_o, 8'hE1);
      wr(4'd0, 16'h8421);
      for (int c = 0; c < 40; c++) tick();

      // R6 lock-up recovery with a zero tap mask
      cur_req = "R6";
      wr(4'd0, 16'h0000);
      early = 0;
      for (int c = 0; c < 20; c++) begin
         if (m_st == 16'h0) early = 1;
         tick();
      end
      check(early == 1, "R6", early, 1);

      // R3 maximal-length taps
      cur_req = "R3";
      wr(4'd0, 16'hD008);
      wr(4'd1, 16'h0001);
      early = 0;
      for (int c = 0; c < 65535; c++) begin
         tick();
         if (c < 65534 && m_st == 16'h0001) early = 1;
      end
      check(m_st == 16'h0001 && rnd_o == 8'h01, "R3", rnd_o, 8'h01);
      check(early == 0, "R3", early, 0);

      done = 1;
      summary();
      $finish;
   end
endmodule